// File: doc/BRIEF.md
# Password Access Controller with Retry Lockout

This block sits behind a byte-level serial front end and decides whether a transaction may reach one of two memory arrays. The front end reports start and stop conditions and each received byte; the block answers every byte with an acknowledge or a refusal. A transaction opens with a command byte and then eight password bytes. The block holds five 64-bit passwords: a read and a write password for each array, and one reset password. It compares the received password with the one the command selects.

Every password load starts a simulated nonvolatile cycle of a set number of clock cycles. The master has to poll with code 0xF0. The poll is acknowledged only after the cycle has ended and only if the password matched. After a successful poll, array commands move on to two address bytes and a data phase, and the block raises a grant flag. The grant carries the array index and whether the access is a write. Password-change commands take eight new password bytes, which are stored at the stop. A retry counter tracks failed passwords. When it overflows, the block strobes an array-clear output and blocks all read and write passwords until a reset-device command arrives with the reset password.

Array storage is outside this block. It sees only the clear strobe and the grant flag.

Top module: `pwa_ctrl`

## Requirements
- R1: After reset, ack_valid_o, grant_o and clear_o are low, and all five stored passwords are zero.
- R2: A command byte received right after a start is acknowledged only if it is one of 0x80, 0x88, 0x90, 0x98, 0xA0, 0xA8, 0xB0, 0xB8, 0xC0, 0xE0 or 0xE8. Every other code is refused and the block goes to standby, and this includes 0xF0 when no password is pending.
- R3: After the eighth password byte, a nonvolatile cycle of WC_CYCLES clocks runs. A 0xF0 poll during that cycle is refused, and the block keeps waiting for a later poll.
- R4: A 0xF0 poll after the cycle has ended is acknowledged if the password matched and refused if it did not. Password bytes are sent most significant byte first. Password slots: read array 0 = 0x80/0xA0, read array 1 = 0x88/0xA8, write array 0 = 0x90/0xB0, write array 1 = 0x98/0xB8, and reset = 0xC0/0xE0/0xE8.
- R5: After an acknowledged poll for 0x80, 0x88, 0x90 or 0x98, grant_o is high. grant_arr_o equals command bit 3 and grant_wr_o equals command bit 4. Both following address bytes are acknowledged, and the grant drops after a stop.
- R6: Failed password loads are counted across all commands. A correct password clears the count. The ninth consecutive failure (MAX_FAIL+1) pulses clear_o for one cycle and locks the block.
- R7: While the block is locked, read and write passwords never match, and further failures give no clear strobe.
- R8: Command 0xE8 with the reset password unlocks the block and clears the count. The stored passwords are left unchanged.
- R9: Command 0xE0 with the reset password pulses clear_o once and sets all five passwords to zero.
- R10: After an acknowledged poll, commands 0xA0 to 0xC0 take two address bytes and then eight new password bytes. A stop after exactly eight new bytes stores them and starts a cycle. A stop after fewer bytes changes nothing.
- R11: Any byte received while a nonvolatile cycle is running is refused. This covers a command byte sent just after a sector-write stop or a password-change stop.
- R12: In a granted write, up to SECTOR_BYTES data bytes are acknowledged and any further byte is refused. A stop after at least one data byte starts a nonvolatile cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start condition seen (one-cycle pulse) |
| stop_i | input | 1 | Stop condition seen (one-cycle pulse) |
| byte_valid_i | input | 1 | A received byte is present on byte_i |
| byte_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | Response to the previous byte is valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| grant_o | output | 1 | Array access granted |
| grant_arr_o | output | 1 | Granted array index |
| grant_wr_o | output | 1 | Granted access is a write |
| clear_o | output | 1 | One-cycle strobe that clears both arrays |

## Verification
The hardest state to reach from the ports is lockout followed by recovery. Reaching it takes nine full failed password loads in a row, each with its own nonvolatile wait and poll. Recovery then needs a reset-device command that uses the one password still allowed to match. The stimulus first sweeps failure runs of length one to eight, each closed by a correct password, to show that the count clears. It then drives nine failures, checks for exactly one clear strobe, and checks that a known good read password now fails. Finally it unlocks the block and checks that the changed password from an earlier step has survived.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
    localparam int NUM_PW = 5;
    localparam logic [7:0] POLL_CODE = 8'hF0;

    typedef logic [2:0] pw_sel_t;
    localparam pw_sel_t SEL_RST = 3'd4;

    typedef enum logic [2:0] {
        K_BAD, K_RD, K_WR, K_CHG, K_RSTPW, K_RSTDEV, K_POLL
    } cmd_kind_e;

    typedef enum logic [2:0] {
        S_STBY, S_CMD, S_PWD, S_POLL, S_ADDR, S_DATA
    } st_e;
endpackage

// File: rtl/pwa_cmd_decode.sv
module pwa_cmd_decode
    import pwa_pkg::*;
(
    input  logic [7:0] code_i,
    output cmd_kind_e  kind_o,
    output logic       arr_o,
    output pw_sel_t    sel_o
);
    // R2: only codes with low three bits zero are legal
    always_comb begin
        kind_o = K_BAD;
        arr_o  = code_i[3];
        sel_o  = {1'b0, code_i[4], code_i[3]};
        if (code_i[2:0] == 3'b000) begin
            unique casez (code_i[7:3])
                5'b1000?: kind_o = K_RD;
                5'b1001?: kind_o = K_WR;
                5'b101??: kind_o = K_CHG;
                5'b11000: begin kind_o = K_CHG;    sel_o = SEL_RST; end
                5'b11100: begin kind_o = K_RSTPW;  sel_o = SEL_RST; end
                5'b11101: begin kind_o = K_RSTDEV; sel_o = SEL_RST; end
                5'b11110: kind_o = K_POLL;
                default:  kind_o = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/pwa_pw_store.sv
module pwa_pw_store
    import pwa_pkg::*;
#(
    parameter int PW_W = 64,
    parameter int NPW  = NUM_PW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pw_sel_t         sel_i,
    input  logic [PW_W-1:0] cand_i,
    input  logic            wr_i,
    input  pw_sel_t         wr_sel_i,
    input  logic [PW_W-1:0] wr_val_i,
    input  logic            zero_i,
    output logic            eq_o
);
    logic [NPW-1:0][PW_W-1:0] pw_all;

    for (genvar g = 0; g < NPW; g++) begin : g_ent
        logic [PW_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (zero_i)                                   val_d = '0;  // R9
            else if (wr_i && (wr_sel_i == pw_sel_t'(g)))  val_d = wr_val_i; // R10
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;   // R1
            else        val_q <= val_d;
        end

        assign pw_all[g] = val_q;
    end

    // full-width compare; the controller samples it only on the last byte
    assign eq_o = (int'(sel_i) < NPW) && (pw_all[sel_i] == cand_i);
endmodule

// File: rtl/pwa_retry.sv
module pwa_retry #(
    parameter int MAX_FAIL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_i,
    input  logic pass_i,
    input  logic unlock_i,
    output logic locked_o,
    output logic wipe_o
);
    localparam int CW = $clog2(MAX_FAIL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          locked;
        logic          wipe;
    } rt_t;

    rt_t q, d;

    always_comb begin
        d      = q;
        d.wipe = 1'b0;
        if (unlock_i) begin          // R8
            d.cnt    = '0;
            d.locked = 1'b0;
        end else if (!q.locked) begin
            if (pass_i) begin
                d.cnt = '0;          // R6
            end else if (fail_i) begin
                if (q.cnt == CW'(MAX_FAIL)) begin
                    d.locked = 1'b1; // R6
                    d.wipe   = 1'b1;
                    d.cnt    = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign locked_o = q.locked;
    assign wipe_o   = q.wipe;
endmodule

// File: rtl/pwa_nv_timer.sv
module pwa_nv_timer #(
    parameter int unsigned WC_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(WC_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tm_t;

    tm_t q, d;

    always_comb begin
        d = q;
        if (start_i)          d.cnt = CW'(WC_CYCLES);   // R3
        else if (q.cnt != '0) d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.cnt != '0);
endmodule

// File: rtl/pwa_ctrl.sv
module pwa_ctrl
    import pwa_pkg::*;
#(
    parameter int unsigned WC_CYCLES    = 1000000,
    parameter int          MAX_FAIL     = 8,
    parameter int          SECTOR_BYTES = 64,
    parameter int          PW_BYTES     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       byte_valid_i,
    input  logic [7:0] byte_i,
    output logic       ack_valid_o,
    output logic       ack_o,
    output logic       grant_o,
    output logic       grant_arr_o,
    output logic       grant_wr_o,
    output logic       clear_o
);
    localparam int PW_W = 8 * PW_BYTES;
    localparam int PCW  = $clog2(PW_BYTES);
    localparam int DCW  = $clog2(SECTOR_BYTES + 1);

    typedef struct packed {
        st_e             st;
        cmd_kind_e       kind;
        logic            arr;
        pw_sel_t         sel;
        logic [PW_W-1:0] shift;
        logic [PCW-1:0]  pcnt;
        logic [DCW-1:0]  dcnt;
        logic            ok;
        logic            ackv;
        logic            ack;
        logic            grant;
        logic            clr;
    } ctl_t;

    ctl_t q, d;

    cmd_kind_e       dec_kind;
    logic            dec_arr;
    pw_sel_t         dec_sel;
    logic [PW_W-1:0] cand;
    logic            pw_eq, match;
    logic            locked, wipe, nv_busy;
    logic            nv_start, fail, pass, unlock, st_wr, zero_all;

    assign cand = {q.shift[PW_W-9:0], byte_i};

    pwa_cmd_decode u_dec (
        .code_i (byte_i),
        .kind_o (dec_kind),
        .arr_o  (dec_arr),
        .sel_o  (dec_sel)
    );

    pwa_pw_store #(.PW_W(PW_W), .NPW(NUM_PW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (q.sel),
        .cand_i   (cand),
        .wr_i     (st_wr),
        .wr_sel_i (q.sel),
        .wr_val_i (q.shift),
        .zero_i   (zero_all),
        .eq_o     (pw_eq)
    );

    pwa_retry #(.MAX_FAIL(MAX_FAIL)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .fail_i   (fail),
        .pass_i   (pass),
        .unlock_i (unlock),
        .locked_o (locked),
        .wipe_o   (wipe)
    );

    pwa_nv_timer #(.WC_CYCLES(WC_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (nv_start),
        .busy_o  (nv_busy)
    );

    // R7: while locked only the reset password may match
    assign match = pw_eq && (!locked || (q.sel == SEL_RST));

    always_comb begin
        d        = q;
        d.ackv   = 1'b0;
        d.ack    = 1'b0;
        d.clr    = 1'b0;
        fail     = 1'b0;
        pass     = 1'b0;
        unlock   = 1'b0;
        nv_start = 1'b0;
        st_wr    = 1'b0;
        zero_all = 1'b0;

        if (stop_i) begin
            if (q.st == S_DATA && q.kind == K_WR && q.dcnt != '0)
                nv_start = 1'b1;                              // R12
            if (q.st == S_DATA && q.kind == K_CHG && q.dcnt == DCW'(PW_BYTES)) begin
                st_wr    = 1'b1;                              // R10
                nv_start = 1'b1;
            end
            d.st = S_STBY;
        end else if (start_i) begin
            if (q.st != S_POLL) d.st = S_CMD;
        end else if (byte_valid_i) begin
            d.ackv = 1'b1;
            unique case (q.st)
                S_CMD: begin
                    if (!nv_busy && dec_kind != K_BAD && dec_kind != K_POLL) begin
                        d.ack  = 1'b1;                        // R2
                        d.kind = dec_kind;
                        d.arr  = dec_arr;
                        d.sel  = dec_sel;
                        d.pcnt = '0;
                        d.st   = S_PWD;
                    end else begin
                        d.st = S_STBY;                        // R2, R11
                    end
                end
                S_PWD: begin
                    d.ack   = 1'b1;
                    d.shift = cand;
                    if (q.pcnt == PCW'(PW_BYTES - 1)) begin
                        d.ok     = match;                     // R4
                        pass     = match;
                        fail     = !match;                    // R6
                        nv_start = 1'b1;                      // R3
                        d.st     = S_POLL;
                    end else begin
                        d.pcnt = q.pcnt + 1'b1;
                    end
                end
                S_POLL: begin
                    if (byte_i == POLL_CODE && nv_busy) begin
                        d.st = S_POLL;                        // R3
                    end else if (byte_i == POLL_CODE && q.ok) begin
                        d.ack = 1'b1;
                        d.ok  = 1'b0;
                        unique case (q.kind)
                            K_RSTDEV: begin unlock = 1'b1; d.st = S_STBY; end // R8
                            K_RSTPW: begin                    // R9
                                zero_all = 1'b1;
                                d.clr    = 1'b1;
                                d.st     = S_STBY;
                            end
                            default: begin d.dcnt = '0; d.st = S_ADDR; end
                        endcase
                    end else begin
                        d.st = S_STBY;                        // R4
                    end
                end
                S_ADDR: begin
                    d.ack = 1'b1;                             // R5
                    if (q.dcnt == DCW'(1)) begin
                        d.dcnt = '0;
                        d.st   = S_DATA;
                    end else begin
                        d.dcnt = q.dcnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (q.kind == K_WR && q.dcnt < DCW'(SECTOR_BYTES)) begin
                        d.ack  = 1'b1;                        // R12
                        d.dcnt = q.dcnt + 1'b1;
                    end else if (q.kind == K_CHG && q.dcnt < DCW'(PW_BYTES)) begin
                        d.ack   = 1'b1;                       // R10
                        d.shift = cand;
                        d.dcnt  = q.dcnt + 1'b1;
                    end
                end
                default: d.st = S_STBY;
            endcase
        end

        d.grant = (d.st == S_ADDR || d.st == S_DATA) &&
                  (d.kind == K_RD || d.kind == K_WR);         // R5
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;                                  // R1
        else        q <= d;
    end

    assign ack_valid_o = q.ackv;
    assign ack_o       = q.ack;
    assign grant_o     = q.grant;
    assign grant_arr_o = q.arr;
    assign grant_wr_o  = (q.kind == K_WR);
    assign clear_o     = q.clr | wipe;                        // R6, R9
endmodule

// File: rtl/pwa_ctrl_chk.sv
module pwa_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic byte_valid_i,
    input logic stop_i,
    input logic ack_valid_o,
    input logic ack_o,
    input logic grant_o,
    input logic clear_o,
    input logic busy,
    input logic locked
);
    a_r1_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> $past(byte_valid_i));

    a_r11_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_i && busy |=> ack_valid_o && !ack_o);

    a_r5_stop_drops_grant: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !grant_o);

    a_r6_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> !clear_o);

    a_r7_no_grant_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> !locked);
endmodule

bind pwa_ctrl pwa_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid_i (byte_valid_i),
    .stop_i       (stop_i),
    .ack_valid_o  (ack_valid_o),
    .ack_o        (ack_o),
    .grant_o      (grant_o),
    .clear_o      (clear_o),
    .busy         (nv_busy),
    .locked       (locked)
);

// File: tb/pwa_ctrl_bench.sv
module pwa_ctrl_bench;
    localparam int WC   = 20;
    localparam int MAXF = 8;
    localparam int SECT = 64;
    localparam logic [63:0] NEWPW = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] BADPW = 64'h5A5A_0000_DEAD_BEEF;

    logic clk = 1'b0;
    logic rst_n, start_i, stop_i, byte_valid_i;
    logic [7:0] byte_i;
    logic ack_valid_o, ack_o, grant_o, grant_arr_o, grant_wr_o, clear_o;

    always #5 clk = ~clk;

    pwa_ctrl #(.WC_CYCLES(WC), .MAX_FAIL(MAXF), .SECTOR_BYTES(SECT), .PW_BYTES(8)) u_pwa_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .ack_valid_o(ack_valid_o), .ack_o(ack_o), .grant_o(grant_o),
        .grant_arr_o(grant_arr_o), .grant_wr_o(grant_wr_o), .clear_o(clear_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int clr_cnt = 0;
    logic [63:0] bpw [5];
    int  b_fails = 0;
    bit  b_locked = 0;
    int  exp_clr = 0;

    always @(posedge clk) begin
        #1;
        if (clear_o) clr_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_start();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    endtask

    task automatic send_stop();
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic av, output logic a);
        byte_i = b; byte_valid_i = 1'b1;
        @(negedge clk);
        byte_valid_i = 1'b0;
        av = ack_valid_o; a = ack_o;
    endtask

    function automatic bit legal(input logic [7:0] c);
        return c inside {8'h80, 8'h88, 8'h90, 8'h98, 8'hA0, 8'hA8,
                         8'hB0, 8'hB8, 8'hC0, 8'hE0, 8'hE8};
    endfunction

    function automatic int sel_of(input logic [7:0] c);
        if (c == 8'hC0 || c == 8'hE0 || c == 8'hE8) return 4;
        return int'({c[4], c[3]});
    endfunction

    task automatic poll(output logic a);
        logic av;
        send_start();
        send_byte(8'hF0, av, a);
    endtask

    // full password load, wait, poll; expectation from bench model
    task automatic auth_chk(input logic [7:0] cmd, input logic [63:0] pw,
                            input string req, input bit keep, output logic ok);
        logic av, a;
        int s;
        bit exp;
        s = sel_of(cmd);
        exp = (bpw[s] == pw) && (!b_locked || s == 4);
        if (!b_locked) begin
            if (exp) b_fails = 0;
            else if (b_fails == MAXF) begin b_locked = 1; b_fails = 0; exp_clr++; end
            else b_fails++;
        end
        send_start();
        send_byte(cmd, av, a);
        for (int i = 0; i < 8; i++) send_byte(pw[63-8*i -: 8], av, a);
        idle(WC + 4);
        poll(ok);
        if (ok && cmd == 8'hE8) begin b_locked = 0; b_fails = 0; end
        if (ok && cmd == 8'hE0) begin
            for (int k = 0; k < 5; k++) bpw[k] = '0;
            exp_clr++;
        end
        chk(ok == exp, req, "poll ack", longint'(ok), longint'(exp));
        idle(2);
        chk(clr_cnt == exp_clr, req, "clear strobes", clr_cnt, exp_clr);
        if (!keep) send_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic av, a, ok;
        int bad_acks;
        for (int k = 0; k < 5; k++) bpw[k] = '0;
        rst_n = 1'b0; start_i = 0; stop_i = 0; byte_valid_i = 0; byte_i = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1
        chk(ack_valid_o == 0, "R1", "ack_valid", ack_valid_o, 0);
        chk(grant_o == 0, "R1", "grant", grant_o, 0);
        chk(clear_o == 0, "R1", "clear", clear_o, 0);

        // R2: sweep every command code
        for (int c = 0; c < 256; c++) begin
            send_start();
            send_byte(8'(c), av, a);
            chk(av == 1 && a == legal(8'(c)), "R2", $sformatf("code %0h", c),
                longint'(a), longint'(legal(8'(c))));
            send_stop();
        end

        // R3: early poll refused, later poll accepted
        send_start();
        send_byte(8'h80, av, a);
        for (int i = 0; i < 8; i++) send_byte(8'h00, av, a);
        idle(2);
        poll(a);
        chk(a == 0, "R3", "poll while busy", a, 0);
        idle(WC + 4);
        poll(a);
        chk(a == 1, "R3", "poll after cycle", a, 1);
        send_stop();

        // R4, R1, R5: each array access with zero passwords
        for (int i = 0; i < 4; i++) begin
            logic [7:0] cmd;
            cmd = 8'h80 | (8'(i >> 1) << 4) | (8'(i & 1) << 3);
            auth_chk(cmd, 64'h0, "R4", 1, ok);
            chk(grant_o == 1, "R5", "grant up", grant_o, 1);
            chk(grant_arr_o == i[0], "R5", "grant array", grant_arr_o, i[0]);
            chk(grant_wr_o == i[1], "R5", "grant write", grant_wr_o, i[1]);
            send_byte(8'h12, av, a);
            chk(a == 1, "R5", "addr hi ack", a, 1);
            send_byte(8'h34, av, a);
            chk(a == 1, "R5", "addr lo ack", a, 1);
            send_stop();
            chk(grant_o == 0, "R5", "grant after stop", grant_o, 0);
        end

        // R12: sector write limit, then R11
        auth_chk(8'h90, 64'h0, "R12", 1, ok);
        send_byte(8'h00, av, a);
        send_byte(8'h00, av, a);
        bad_acks = 0;
        for (int i = 0; i < SECT; i++) begin
            send_byte(8'(i), av, a);
            if (a != 1) bad_acks++;
        end
        chk(bad_acks == 0, "R12", "sector bytes refused", bad_acks, 0);
        send_byte(8'hFF, av, a);
        chk(a == 0, "R12", "byte past sector", a, 0);
        send_stop();
        send_start();
        send_byte(8'h80, av, a);
        chk(av == 1 && a == 0, "R11", "cmd during write cycle", a, 0);
        send_stop();
        idle(WC + 4);

        // R10: change read-0 password
        auth_chk(8'hA0, 64'h0, "R10", 1, ok);
        send_byte(8'h00, av, a);
        send_byte(8'h00, av, a);
        for (int i = 0; i < 8; i++) send_byte(NEWPW[63-8*i -: 8], av, a);
        send_stop();
        bpw[0] = NEWPW;
        send_start();
        send_byte(8'hA8, av, a);
        chk(a == 0, "R11", "cmd during change cycle", a, 0);
        send_stop();
        idle(WC + 4);
        auth_chk(8'h80, 64'h0, "R10", 0, ok);
        auth_chk(8'h80, NEWPW, "R10", 0, ok);
        // short change is discarded
        auth_chk(8'hA8, 64'h0, "R10", 1, ok);
        send_byte(8'h00, av, a);
        send_byte(8'h00, av, a);
        for (int i = 0; i < 5; i++) send_byte(8'hEE, av, a);
        send_stop();
        idle(WC + 4);
        auth_chk(8'h88, 64'h0, "R10", 0, ok);

        // R6: runs of 1..MAXF failures cleared by a correct password
        for (int k = 1; k <= MAXF; k++) begin
            for (int j = 0; j < k; j++) auth_chk(8'h98, BADPW, "R6", 0, ok);
            auth_chk(8'h98, 64'h0, "R6", 0, ok);
        end
        // R6: overflow
        for (int j = 0; j <= MAXF; j++) auth_chk(8'h88, BADPW, "R6", 0, ok);
        chk(b_locked == 1, "R6", "model locked", b_locked, 1);
        // R7: locked
        auth_chk(8'h80, NEWPW, "R7", 0, ok);
        auth_chk(8'h90, BADPW, "R7", 0, ok);
        // R8: unlock with reset password
        auth_chk(8'hE8, 64'h0, "R8", 0, ok);
        auth_chk(8'h80, NEWPW, "R8", 0, ok);
        auth_chk(8'h88, 64'h0, "R8", 0, ok);
        // R9: reset-password command
        auth_chk(8'hE0, 64'h0, "R9", 0, ok);
        auth_chk(8'h80, 64'h0, "R9", 0, ok);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule